// File: doc/BRIEF.md
# Serial Peripheral Slave with Deferred Write Commit

This block is the serial front end of a small byte-addressed store. A host talks to it over a four-wire SPI link in mode 0. Each transaction opens with an 8-bit command byte, continues with one address byte, and then carries data bytes in either direction. Read data streams out from the store as long as the slave stays selected. Write data is not sent to the store while the transaction runs. It is collected in a small staging buffer and is released only when the host deselects the slave exactly at the end of a complete write.

Releasing a write starts an internal programming cycle. While that cycle runs, the busy flag is high and the staged bytes drain into the store through a valid/ready write port. The store may hold off a write by keeping ready low. Address and data then stay unchanged until the transfer is accepted, and the programming cycle is stretched until every staged byte has been taken. A programming cycle always finishes, whatever the chip-select pin does in the meantime. Any transaction that begins while busy is high is ignored completely.

The chip-select and serial-clock pins are brought into the system clock domain through two-flop synchronizers followed by edge detectors. For this reason the serial clock may run at no more than a quarter of the system clock rate.

Top module: `spi_commit_slave`

## Requirements
- R1: While reset is held, and directly after it is released, `so_oe`, `busy` and `st_wr_valid` are all 0.
- R2: If `cs_n` is already low when reset is released, that selection is ignored. Nothing is accepted until `cs_n` has gone high and then low again. Bytes clocked in during the ignored selection write nothing, and `so_oe` stays 0.
- R3: SI is sampled on each rising SCK edge, most significant bit first. The first byte of a transaction is the command: 0x12 means write and 0x13 means read. The second byte is the start address.
- R4: Write data reaches the store only after `cs_n` rises at the end of a write. Staged byte k is written to address start+k. `st_wr_valid` is never 1 while `busy` is 0.
- R5: A write whose `cs_n` rise comes part-way through a byte is discarded. A write that carries no data byte is also discarded. In both cases nothing reaches the store.
- R6: The staging buffer holds STAGE_DEPTH bytes (8 by default). Later bytes wrap around to slot 0 and replace earlier ones. A longer burst therefore commits exactly STAGE_DEPTH bytes, each holding the last value sent for its slot.
- R7: A commit holds `busy` high for PROG_CYCLES system clocks (16 by default) when the store never stalls. The commit runs to completion even if `cs_n` is taken low again while it runs.
- R8: Any transaction whose `cs_n` fall arrives while `busy` is high is ignored for its whole length. It writes nothing, and `so_oe` stays 0 during it.
- R9: After a read command and its address byte, SO changes only after falling SCK edges. It presents the store byte at the current address, most significant bit first. The address then increments for each further byte while `cs_n` stays low.
- R10: `so_oe` is 1 during an accepted transaction. It returns to 0 within a few system clocks after `cs_n` goes high.
- R11: A command byte other than 0x12 or 0x13 causes the rest of that transaction to be ignored.
- R12: Write port back-pressure: while `st_wr_valid` is 1 and `st_wr_ready` is 0, address and data hold steady, and `busy` stays high until every staged byte has been accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock, mode 0, at most clk/4 |
| si | input | 1 | Serial data in |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for SO; SO is high impedance when 0 |
| busy | output | 1 | Programming cycle in progress |
| st_wr_valid | output | 1 | Store write request |
| st_wr_ready | input | 1 | Store accepts the write request |
| st_wr_addr | output | ADDR_W | Store write address |
| st_wr_data | output | 8 | Store write data |
| st_rd_addr | output | ADDR_W | Store read address |
| st_rd_data | input | 8 | Store read data, combinational from st_rd_addr |

## Verification
The bench builds the block with its default parameters: an 8-bit address, an 8-byte staging buffer and a 16-clock programming cycle. Sixteen clocks is longer than it takes to drain the full buffer, so with ready held high the observed busy length equals the parameter exactly. A ten-byte burst wraps the buffer and overwrites two slots, which shows the replacement order at the store. A separate run holds ready low for many cycles to show that the cycle stretches and that the request stays steady.

// File: rtl/spi_commit_pkg.sv
package spi_commit_pkg;
  localparam logic [7:0] CMD_WRITE = 8'h12;
  localparam logic [7:0] CMD_READ  = 8'h13;

  typedef enum logic [2:0] {
    PH_CMD,
    PH_ADDR,
    PH_WDATA,
    PH_RDATA,
    PH_SKIP
  } phase_t;
endpackage

// File: rtl/spi_edge_sync.sv
module spi_edge_sync #(
  parameter int STAGES = 2,
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= {STAGES{RST_VAL}};
      prev  <= RST_VAL;
    end else begin
      chain <= {chain[STAGES-2:0], d};
      prev  <= chain[STAGES-1];
    end
  end

  assign rise = chain[STAGES-1] & ~prev;
  assign fall = ~chain[STAGES-1] & prev;
endmodule

// File: rtl/spi_stage_buf.sv
module spi_stage_buf #(
  parameter int DEPTH = 8,
  parameter int W = 8,
  localparam int IDXW = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [IDXW-1:0] widx,
  input  logic [W-1:0]    din,
  input  logic [IDXW-1:0] ridx,
  output logic [W-1:0]    dout
);
  logic [W-1:0] slot [DEPTH];

  for (genvar e = 0; e < DEPTH; e++) begin : g_slot
    logic [W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          q <= '0;
      else if (we && widx == IDXW'(e))     q <= din;
    end
    assign slot[e] = q;
  end

  assign dout = slot[ridx];
endmodule

// File: rtl/spi_frame_rx.sv
module spi_frame_rx
  import spi_commit_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DEPTH = 8,
  localparam int IDXW = $clog2(DEPTH),
  localparam int CNTW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_fall,
  input  logic              cs_rise,
  input  logic              sck_rise,
  input  logic              sck_fall,
  input  logic              si_bit,
  input  logic              busy,
  input  logic [7:0]        rd_data,
  output logic              active,
  output logic              so_bit,
  output logic              stage_we,
  output logic [IDXW-1:0]   stage_idx,
  output logic [7:0]        stage_din,
  output logic              commit_go,
  output logic [ADDR_W-1:0] commit_base,
  output logic [CNTW-1:0]   commit_cnt,
  output logic [ADDR_W-1:0] rd_addr
);
  phase_t            phase;
  logic [2:0]        bitcnt;
  logic [6:0]        sh;
  logic [7:0]        obyte;
  logic              is_wr;
  logic              load_pend;
  logic              so_q;
  logic [ADDR_W-1:0] ptr;
  logic [IDXW-1:0]   sidx;
  logic [CNTW-1:0]   wcount;
  logic [7:0]        nxt;
  logic              byte_done;

  assign nxt       = {sh, si_bit};
  assign byte_done = active && sck_rise && (bitcnt == 3'd7);

  assign stage_we    = byte_done && (phase == PH_WDATA);
  assign stage_idx   = sidx;
  assign stage_din   = nxt;
  assign commit_go   = cs_rise && active && (phase == PH_WDATA) &&
                       (bitcnt == 3'd0) && (wcount != '0);
  assign commit_base = ptr;
  assign commit_cnt  = wcount;
  assign rd_addr     = ptr;
  assign so_bit      = so_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active    <= 1'b0;
      phase     <= PH_CMD;
      bitcnt    <= '0;
      sh        <= '0;
      obyte     <= '0;
      is_wr     <= 1'b0;
      load_pend <= 1'b0;
      so_q      <= 1'b0;
      ptr       <= '0;
      sidx      <= '0;
      wcount    <= '0;
    end else begin
      load_pend <= 1'b0;
      if (load_pend) begin
        obyte <= rd_data;
        ptr   <= ptr + 1'b1;
      end
      if (cs_rise) begin
        active <= 1'b0;
        phase  <= PH_CMD;
        bitcnt <= '0;
      end else if (cs_fall && !busy) begin
        active <= 1'b1;
        phase  <= PH_CMD;
        bitcnt <= '0;
        sidx   <= '0;
        wcount <= '0;
      end else if (active && sck_rise) begin
        bitcnt <= bitcnt + 3'd1;
        sh     <= nxt[6:0];
        if (bitcnt == 3'd7) begin
          unique case (phase)
            PH_CMD: begin
              if (nxt == CMD_WRITE) begin
                phase <= PH_ADDR;
                is_wr <= 1'b1;
              end else if (nxt == CMD_READ) begin
                phase <= PH_ADDR;
                is_wr <= 1'b0;
              end else begin
                phase <= PH_SKIP;
              end
            end
            PH_ADDR: begin
              ptr <= ADDR_W'(nxt);
              if (is_wr) begin
                phase <= PH_WDATA;
              end else begin
                phase     <= PH_RDATA;
                load_pend <= 1'b1;
              end
            end
            PH_WDATA: begin
              sidx <= (sidx == IDXW'(DEPTH - 1)) ? '0 : sidx + 1'b1;
              if (wcount != CNTW'(DEPTH)) wcount <= wcount + 1'b1;
            end
            PH_RDATA: load_pend <= 1'b1;
            default: ;
          endcase
        end
      end
      if (active && sck_fall && phase == PH_RDATA)
        so_q <= obyte[3'd7 - bitcnt];
    end
  end
endmodule

// File: rtl/spi_commit_eng.sv
module spi_commit_eng #(
  parameter int ADDR_W = 8,
  parameter int DEPTH = 8,
  parameter int PROG_CYCLES = 16,
  localparam int IDXW = $clog2(DEPTH),
  localparam int CNTW = $clog2(DEPTH + 1),
  localparam int TW = $clog2(PROG_CYCLES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] base,
  input  logic [CNTW-1:0]   cnt,
  input  logic [7:0]        stage_dout,
  input  logic              wr_ready,
  output logic [IDXW-1:0]   stage_ridx,
  output logic              busy,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data
);
  logic [TW-1:0]     tmr;
  logic [CNTW-1:0]   idx;
  logic [CNTW-1:0]   cnt_q;
  logic [ADDR_W-1:0] base_q;
  logic              drained;

  assign drained    = (idx == cnt_q);
  assign wr_valid   = busy && (idx < cnt_q);
  assign wr_addr    = base_q + ADDR_W'(idx);
  assign wr_data    = stage_dout;
  assign stage_ridx = idx[IDXW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      tmr    <= '0;
      idx    <= '0;
      cnt_q  <= '0;
      base_q <= '0;
    end else if (start && !busy) begin
      busy   <= 1'b1;
      tmr    <= TW'(1);
      idx    <= '0;
      cnt_q  <= cnt;
      base_q <= base;
    end else if (busy) begin
      if (tmr != TW'(PROG_CYCLES)) tmr <= tmr + 1'b1;
      if (wr_valid && wr_ready)    idx <= idx + 1'b1;
      if (tmr == TW'(PROG_CYCLES) && drained) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/spi_commit_slave.sv
module spi_commit_slave #(
  parameter int ADDR_W = 8,
  parameter int STAGE_DEPTH = 8,
  parameter int PROG_CYCLES = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sck,
  input  logic              si,
  output logic              so,
  output logic              so_oe,
  output logic              busy,
  output logic              st_wr_valid,
  input  logic              st_wr_ready,
  output logic [ADDR_W-1:0] st_wr_addr,
  output logic [7:0]        st_wr_data,
  output logic [ADDR_W-1:0] st_rd_addr,
  input  logic [7:0]        st_rd_data
);
  localparam int IDXW = $clog2(STAGE_DEPTH);
  localparam int CNTW = $clog2(STAGE_DEPTH + 1);

  logic cs_rise, cs_fall, sck_rise, sck_fall;
  logic [SYNC_STAGES-1:0] si_chain;
  logic active, stage_we, commit_go;
  logic [IDXW-1:0] stage_widx, stage_ridx;
  logic [7:0] stage_din, stage_dout;
  logic [ADDR_W-1:0] commit_base;
  logic [CNTW-1:0] commit_cnt;

  // Chip select resets to "low" so a selection already present at reset shows no fall.
  spi_edge_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_cs_sync (
    .clk(clk), .rst_n(rst_n), .d(cs_n), .rise(cs_rise), .fall(cs_fall));

  spi_edge_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sck_sync (
    .clk(clk), .rst_n(rst_n), .d(sck), .rise(sck_rise), .fall(sck_fall));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) si_chain <= '0;
    else        si_chain <= {si_chain[SYNC_STAGES-2:0], si};
  end

  spi_frame_rx #(.ADDR_W(ADDR_W), .DEPTH(STAGE_DEPTH)) u_rx (
    .clk(clk), .rst_n(rst_n),
    .cs_fall(cs_fall), .cs_rise(cs_rise),
    .sck_rise(sck_rise), .sck_fall(sck_fall),
    .si_bit(si_chain[SYNC_STAGES-1]), .busy(busy),
    .rd_data(st_rd_data), .active(active), .so_bit(so),
    .stage_we(stage_we), .stage_idx(stage_widx), .stage_din(stage_din),
    .commit_go(commit_go), .commit_base(commit_base), .commit_cnt(commit_cnt),
    .rd_addr(st_rd_addr));

  spi_stage_buf #(.DEPTH(STAGE_DEPTH), .W(8)) u_stage (
    .clk(clk), .rst_n(rst_n), .we(stage_we), .widx(stage_widx),
    .din(stage_din), .ridx(stage_ridx), .dout(stage_dout));

  spi_commit_eng #(.ADDR_W(ADDR_W), .DEPTH(STAGE_DEPTH), .PROG_CYCLES(PROG_CYCLES)) u_eng (
    .clk(clk), .rst_n(rst_n), .start(commit_go), .base(commit_base),
    .cnt(commit_cnt), .stage_dout(stage_dout), .wr_ready(st_wr_ready),
    .stage_ridx(stage_ridx), .busy(busy), .wr_valid(st_wr_valid),
    .wr_addr(st_wr_addr), .wr_data(st_wr_data));

  assign so_oe = active;
endmodule

// File: rtl/spi_commit_slave_chk.sv
module spi_commit_slave_chk #(
  parameter int ADDR_W = 8,
  parameter int PROG_CYCLES = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_n,
  input logic              so_oe,
  input logic              busy,
  input logic              st_wr_valid,
  input logic              st_wr_ready,
  input logic [ADDR_W-1:0] st_wr_addr,
  input logic [7:0]        st_wr_data
);
  logic [15:0] busy_run;
  logic [2:0]  cs_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_run <= '0;
      cs_hi    <= '0;
    end else begin
      if (busy) busy_run <= (busy_run == 16'hFFFF) ? busy_run : busy_run + 16'd1;
      else      busy_run <= '0;
      if (cs_n) cs_hi <= (cs_hi == 3'd7) ? cs_hi : cs_hi + 3'd1;
      else      cs_hi <= '0;
    end
  end

  AST_NO_WR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !st_wr_valid); // R4
  AST_BUSY_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && busy_run != 16'd0) |-> (busy_run >= 16'(PROG_CYCLES))); // R7
  AST_BUSY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !so_oe); // R8
  AST_OE_DESEL: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_hi >= 3'd4) |-> !so_oe); // R10
  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (st_wr_valid && !st_wr_ready) |=>
      (st_wr_valid && $stable(st_wr_addr) && $stable(st_wr_data))); // R12
endmodule

bind spi_commit_slave spi_commit_slave_chk #(.ADDR_W(ADDR_W), .PROG_CYCLES(PROG_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .so_oe(so_oe), .busy(busy),
  .st_wr_valid(st_wr_valid), .st_wr_ready(st_wr_ready),
  .st_wr_addr(st_wr_addr), .st_wr_data(st_wr_data));

// File: tb/spi_commit_slave_tb.sv
module spi_commit_slave_tb_top;
  localparam int HALF = 5;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, cs_n, sck, si, so, so_oe, busy;
  logic st_wr_valid, st_wr_ready;
  logic [7:0] st_wr_addr, st_wr_data, st_rd_addr, st_rd_data;
  logic [7:0] mem [256];
  int wcnt = 0;
  int total = 0;
  int bad = 0;

  spi_commit_slave dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
    .so(so), .so_oe(so_oe), .busy(busy),
    .st_wr_valid(st_wr_valid), .st_wr_ready(st_wr_ready),
    .st_wr_addr(st_wr_addr), .st_wr_data(st_wr_data),
    .st_rd_addr(st_rd_addr), .st_rd_data(st_rd_data));

  function automatic logic [7:0] init_val(input logic [7:0] a);
    return a ^ 8'h5A;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= init_val(8'(i));
    end else if (st_wr_valid && st_wr_ready) begin
      mem[st_wr_addr] <= st_wr_data;
      wcnt = wcnt + 1;
    end
  end
  assign st_rd_data = mem[st_rd_addr];

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      si = tx[i];
      tick(HALF);
      rx[i] = so;
      sck = 1'b1;
      tick(HALF);
      sck = 1'b0;
    end
  endtask

  task automatic send(input logic [7:0] tx);
    logic [7:0] dummy;
    xfer(tx, dummy);
  endtask

  task automatic send_bits(input logic [7:0] tx, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      si = tx[i];
      tick(HALF);
      sck = 1'b1;
      tick(HALF);
      sck = 1'b0;
    end
  endtask

  task automatic sel();
    cs_n = 1'b0;
    tick(2 * HALF);
  endtask

  task automatic desel();
    tick(HALF);
    cs_n = 1'b1;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 400 && busy; i++) tick(1);
  endtask

  task automatic t_reset_held_sel();
    tick(1);
    check(so_oe == 1'b0, "R1 so_oe", so_oe, 0);
    check(busy == 1'b0, "R1 busy", busy, 0);
    check(st_wr_valid == 1'b0, "R1 wr_valid", st_wr_valid, 0);
    tick(2 * HALF);
    send(8'h12); send(8'h05); send(8'hAA);
    check(so_oe == 1'b0, "R2 so_oe in stale select", so_oe, 0);
    desel();
    tick(40);
    check(wcnt == 0, "R2 write count", wcnt, 0);
    check(mem[5] == init_val(8'h05), "R2 mem[05]", mem[5], init_val(8'h05));
  endtask

  task automatic t_write_basic();
    int n = 0;
    int w0 = wcnt;
    sel();
    send(8'h12); send(8'h10); send(8'hA1); send(8'hB2); send(8'hC3);
    check(wcnt == w0, "R4 nothing before cs rise", wcnt - w0, 0);
    desel();
    for (int i = 0; i < 10 && !busy; i++) tick(1);
    while (busy && n < 100) begin
      n++;
      tick(1);
    end
    check(n == 16, "R7 busy length", n, 16);
    check(mem[8'h10] == 8'hA1, "R4 mem[10]", mem[8'h10], 8'hA1);
    check(mem[8'h11] == 8'hB2, "R4 mem[11]", mem[8'h11], 8'hB2);
    check(mem[8'h12] == 8'hC3, "R4 mem[12]", mem[8'h12], 8'hC3);
    check(wcnt - w0 == 3, "R4 write count", wcnt - w0, 3);
  endtask

  task automatic t_read_stream();
    logic [7:0] rx;
    logic [7:0] exp [4];
    exp[0] = 8'hA1; exp[1] = 8'hB2; exp[2] = 8'hC3; exp[3] = init_val(8'h13);
    sel();
    send(8'h13); send(8'h10);
    check(so_oe == 1'b1, "R10 so_oe while selected", so_oe, 1);
    for (int k = 0; k < 4; k++) begin
      xfer(8'h00, rx);
      check(rx == exp[k], "R9 R3 read byte", rx, exp[k]);
    end
    desel();
    tick(6);
    check(so_oe == 1'b0, "R10 so_oe after deselect", so_oe, 0);
  endtask

  task automatic t_bad_endings();
    int w0 = wcnt;
    sel();
    send(8'h12); send(8'h20); send(8'h55); send_bits(8'hE0, 3);
    desel();
    tick(40);
    check(wcnt == w0, "R5 mid-byte abort count", wcnt - w0, 0);
    check(mem[8'h20] == init_val(8'h20), "R5 mem[20]", mem[8'h20], init_val(8'h20));
    sel();
    send(8'h12); send(8'h21);
    desel();
    tick(40);
    check(wcnt == w0, "R5 empty write count", wcnt - w0, 0);
    check(mem[8'h21] == init_val(8'h21), "R5 mem[21]", mem[8'h21], init_val(8'h21));
  endtask

  task automatic t_bad_cmd();
    int w0 = wcnt;
    sel();
    send(8'h03); send(8'h70); send(8'h99);
    desel();
    tick(40);
    check(wcnt == w0, "R11 unknown command count", wcnt - w0, 0);
    check(mem[8'h70] == init_val(8'h70), "R11 mem[70]", mem[8'h70], init_val(8'h70));
  endtask

  task automatic t_wrap();
    int w0 = wcnt;
    logic [7:0] e;
    sel();
    send(8'h12); send(8'h40);
    for (int k = 0; k < 10; k++) send(8'h30 + 8'(k));
    desel();
    tick(4);
    wait_idle();
    tick(2);
    for (int k = 0; k < 8; k++) begin
      e = (k < 2) ? 8'h38 + 8'(k) : 8'h30 + 8'(k);
      check(mem[8'h40 + 8'(k)] == e, "R6 wrapped slot", mem[8'h40 + 8'(k)], e);
    end
    check(mem[8'h48] == init_val(8'h48), "R6 past block", mem[8'h48], init_val(8'h48));
    check(wcnt - w0 == 8, "R6 write count", wcnt - w0, 8);
  endtask

  task automatic t_busy_ignore();
    int w0 = wcnt;
    sel();
    send(8'h12); send(8'h60); send(8'hC3);
    desel();
    tick(6);
    check(busy == 1'b1, "R7 busy after commit", busy, 1);
    cs_n = 1'b0;
    tick(4);
    check(so_oe == 1'b0, "R8 so_oe for late select", so_oe, 0);
    send(8'h12); send(8'h61); send(8'h77);
    desel();
    tick(40);
    check(mem[8'h60] == 8'hC3, "R7 commit while reselected", mem[8'h60], 8'hC3);
    check(mem[8'h61] == init_val(8'h61), "R8 ignored write", mem[8'h61], init_val(8'h61));
    check(wcnt - w0 == 1, "R8 write count", wcnt - w0, 1);
  endtask

  task automatic t_backpressure();
    int w0 = wcnt;
    st_wr_ready = 1'b0;
    sel();
    send(8'h12); send(8'h80); send(8'h11); send(8'h22);
    desel();
    tick(40);
    check(busy == 1'b1, "R12 busy stretched", busy, 1);
    check(st_wr_valid == 1'b1, "R12 valid held", st_wr_valid, 1);
    check(st_wr_addr == 8'h80, "R12 addr held", st_wr_addr, 8'h80);
    check(wcnt == w0, "R12 no write while stalled", wcnt - w0, 0);
    st_wr_ready = 1'b1;
    wait_idle();
    tick(2);
    check(mem[8'h80] == 8'h11, "R12 mem[80]", mem[8'h80], 8'h11);
    check(mem[8'h81] == 8'h22, "R12 mem[81]", mem[8'h81], 8'h22);
    check(busy == 1'b0, "R12 busy released", busy, 0);
  endtask

  initial begin
    rst_n = 1'b0;
    cs_n = 1'b0;
    sck = 1'b0;
    si = 1'b0;
    st_wr_ready = 1'b1;
    tick(5);
    check(so_oe == 1'b0 && busy == 1'b0, "R1 during reset", {so_oe, busy}, 0);
    rst_n = 1'b1;
    t_reset_held_sel();
    tick(10);
    t_write_basic();
    tick(10);
    t_read_stream();
    tick(10);
    t_bad_endings();
    tick(10);
    t_bad_cmd();
    tick(10);
    t_wrap();
    tick(10);
    t_busy_ignore();
    tick(10);
    t_backpressure();
    tick(10);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule